// File: doc/BRIEF.md
# Multiply Unit with Overflow Flags

This block multiplies two 32-bit operands in one of five ways and registers every result, so the outputs are due one clock after the request. Two forms return the low 32 bits of the product to a destination register. One is signed and one is unsigned. A third form multiplies the first operand by a sign-extended 16-bit immediate. Two double-width forms produce the full 64-bit product and send it to the accumulator halves. They give no register result.

The signed forms report 32-bit signed overflow on the OV flag. The unsigned form reports 32-bit unsigned overflow on the CY flag. Each flag update comes with its own write strobe. A flag whose strobe is low keeps its old value in the surrounding status register. A range exception is requested when the flag that the operation updates is set and the exception enable input is high. The surrounding pipeline decodes the 4-bit ALU sub-code onto `op_code`. It raises `imm_sel` for the immediate form.

Top module: `mul_ovf_unit`

## Requirements
- R1: With `imm_sel`=0 and `op_code`=4'h6, the unit returns the low 32 bits of the signed product and raises `rd_we`.
- R2: For the signed register form, `ov_we`=1, and `ov_val`=1 exactly when the true product lies outside the signed 32-bit range; `cy_we`=0.
- R3: With `imm_sel`=0 and `op_code`=4'hB, the unit returns the low 32 bits of the unsigned product with `rd_we`=1. It sets `cy_we`=1, with `cy_val`=1 exactly when the product exceeds 2^32-1. `ov_we`=0.
- R4: `range_exc` is 1 exactly when the operation updates a flag, that flag's new value is 1, and `range_en`=1.
- R5: With `op_code`=4'h7, both operands are sign-extended to 64 bits. The product's upper half goes to `acc_hi` and its lower half to `acc_lo`, with `acc_we`=1. `rd_we`, `ov_we`, `cy_we` and `range_exc` stay 0.
- R6: With `op_code`=4'hD, both operands are zero-extended and the 64-bit product goes to `acc_hi`/`acc_lo` in the same way. No register write, flag write or exception occurs.
- R7: With `imm_sel`=1, whatever the value of `op_code`, `op_a` is multiplied by the sign-extended `op_imm`. The low 32 bits are returned with `rd_we`=1. Only OV is updated, by the signed overflow rule.
- R8: All outputs are registered. Results are due on the clock edge after the one that samples `in_valid`=1. A cycle with `in_valid`=0 yields all strobes and `range_exc` low on the next edge.
- R9: Any other `op_code` with `imm_sel`=0 yields no strobe and no exception.
- R10: While `rst_n` is low, all strobes and `range_exc` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| imm_sel | input | 1 | Select the immediate multiply |
| op_code | input | 4 | ALU sub-code of the register forms |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand (register forms) |
| op_imm | input | 16 | Immediate, sign-extended |
| range_en | input | 1 | Range exception enable |
| rd_we | output | 1 | Destination register write enable |
| rd_data | output | 32 | Destination result |
| acc_we | output | 1 | Accumulator write strobe |
| acc_hi | output | 32 | Upper half of the 64-bit product |
| acc_lo | output | 32 | Lower half of the 64-bit product |
| ov_we | output | 1 | OV update strobe |
| ov_val | output | 1 | New OV value |
| cy_we | output | 1 | CY update strobe |
| cy_val | output | 1 | New CY value |
| range_exc | output | 1 | Range exception request |

## Verification
Every result, strobe, flag and exception is due exactly one rising edge after the edge that samples the request. The bench drives each request on a falling edge and compares the outputs on the following falling edge, which lies half a period after that single register stage. One idle cycle is then inserted and checked, to confirm that the strobes drop on the edge after `in_valid` falls. The data outputs are compared only in cycles where their strobe is expected, because their value is not defined otherwise.

// File: rtl/mul_ovf_unit.sv
module mul_ovf_unit #(
  parameter int W     = 32,
  parameter int IMM_W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         imm_sel,
  input  logic [3:0]   op_code,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [IMM_W-1:0] op_imm,
  input  logic         range_en,
  output logic         rd_we,
  output logic [W-1:0] rd_data,
  output logic         acc_we,
  output logic [W-1:0] acc_hi,
  output logic [W-1:0] acc_lo,
  output logic         ov_we,
  output logic         ov_val,
  output logic         cy_we,
  output logic         cy_val,
  output logic         range_exc
);
  localparam int PW = 2 * W;
  localparam logic [3:0] C_MUL   = 4'h6;
  localparam logic [3:0] C_MULD  = 4'h7;
  localparam logic [3:0] C_MULU  = 4'hB;
  localparam logic [3:0] C_MULDU = 4'hD;

  logic [W-1:0]  b_eff;
  logic [PW-1:0] s_prod, u_prod, d_prod;
  logic          s_ovf, u_ovf;
  logic          is_sgn, is_uns, is_dbl;

  assign b_eff  = imm_sel ? {{(W-IMM_W){op_imm[IMM_W-1]}}, op_imm} : op_b;
  assign s_prod = {{W{op_a[W-1]}}, op_a} * {{W{b_eff[W-1]}}, b_eff};
  assign u_prod = {{W{1'b0}}, op_a} * {{W{1'b0}}, op_b};

  assign s_ovf  = !((&s_prod[PW-1:W-1]) || !(|s_prod[PW-1:W-1]));
  assign u_ovf  = |u_prod[PW-1:W];

  assign is_sgn = imm_sel || (op_code == C_MUL);
  assign is_uns = !imm_sel && (op_code == C_MULU);
  assign is_dbl = !imm_sel && (op_code == C_MULD || op_code == C_MULDU);
  assign d_prod = (op_code == C_MULD) ? s_prod : u_prod;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_we     <= 1'b0;
      acc_we    <= 1'b0;
      ov_we     <= 1'b0;
      cy_we     <= 1'b0;
      range_exc <= 1'b0;
      ov_val    <= 1'b0;
      cy_val    <= 1'b0;
      rd_data   <= '0;
      acc_hi    <= '0;
      acc_lo    <= '0;
    end else begin
      rd_we     <= in_valid && (is_sgn || is_uns);
      acc_we    <= in_valid && is_dbl;
      ov_we     <= in_valid && is_sgn;
      cy_we     <= in_valid && is_uns;
      range_exc <= in_valid && range_en && ((is_sgn && s_ovf) || (is_uns && u_ovf));
      if (in_valid && is_sgn) ov_val <= s_ovf;
      if (in_valid && is_uns) cy_val <= u_ovf;
      if (in_valid && (is_sgn || is_uns))
        rd_data <= is_sgn ? s_prod[W-1:0] : u_prod[W-1:0];
      if (in_valid && is_dbl) begin
        acc_hi <= d_prod[PW-1:W];
        acc_lo <= d_prod[W-1:0];
      end
    end
  end

  // R5 / R6: an accumulator write excludes register and flag writes
  p_acc_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_we |-> !rd_we && !ov_we && !cy_we && !range_exc);

  // R2 / R3: each register result updates exactly one flag
  p_one_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> $onehot0({ov_we, cy_we}) && (ov_we || cy_we));

  // R4: an exception needs a freshly set flag
  p_exc_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    range_exc |-> (ov_we && ov_val) || (cy_we && cy_val));

  // R8: no strobe follows an idle input cycle
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !rd_we && !acc_we && !ov_we && !cy_we && !range_exc);

  // R7: the immediate form never touches CY
  p_imm_no_cy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && imm_sel) |=> ov_we && !cy_we);
endmodule

// File: tb/mul_ovf_unit_bench.sv
module mul_ovf_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        imm_sel = 1'b0;
  logic [3:0]  op_code = 4'h0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [15:0] op_imm = '0;
  logic        range_en = 1'b0;
  logic        rd_we, acc_we, ov_we, ov_val, cy_we, cy_val, range_exc;
  logic [31:0] rd_data, acc_hi, acc_lo;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mul_ovf_unit u_mul_ovf_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .imm_sel(imm_sel),
    .op_code(op_code), .op_a(op_a), .op_b(op_b), .op_imm(op_imm),
    .range_en(range_en), .rd_we(rd_we), .rd_data(rd_data), .acc_we(acc_we),
    .acc_hi(acc_hi), .acc_lo(acc_lo), .ov_we(ov_we), .ov_val(ov_val),
    .cy_we(cy_we), .cy_val(cy_val), .range_exc(range_exc)
  );

  typedef struct packed {
    logic [7:0]  req;
    logic        isel;
    logic [3:0]  code;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] imm;
    logic        en;
    logic        e_rdwe;
    logic [31:0] e_rd;
    logic        e_accwe;
    logic [31:0] e_hi;
    logic [31:0] e_lo;
    logic        e_ovwe;
    logic        e_ov;
    logic        e_cywe;
    logic        e_cy;
    logic        e_exc;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    // R1 plain signed
    '{8'd1, 1'b0, 4'h6, 32'd3, 32'd5, 16'h0, 1'b1, 1'b1, 32'd15, 1'b0, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    // R2 + R4 signed overflow with exception
    '{8'd2, 1'b0, 4'h6, 32'h0001_0000, 32'h0001_0000, 16'h0, 1'b1, 1'b1, 32'h0, 1'b0, 32'h0, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    // R1 negative operand
    '{8'd1, 1'b0, 4'h6, 32'hFFFF_FFFE, 32'd3, 16'h0, 1'b1, 1'b1, 32'hFFFF_FFFA, 1'b0, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    // R2 + R4 overflow to 2^31, exception disabled
    '{8'd2, 1'b0, 4'h6, 32'h4000_0000, 32'd2, 16'h0, 1'b0, 1'b1, 32'h8000_0000, 1'b0, 32'h0, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    // R3 unsigned, fits
    '{8'd3, 1'b0, 4'hB, 32'hFFFF_FFFF, 32'd1, 16'h0, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    // R3 + R4 unsigned carry with exception
    '{8'd3, 1'b0, 4'hB, 32'h8000_0000, 32'd2, 16'h0, 1'b1, 1'b1, 32'h0, 1'b0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
    // R3 large unsigned, fits
    '{8'd3, 1'b0, 4'hB, 32'h0001_0000, 32'h0000_FFFF, 16'h0, 1'b1, 1'b1, 32'hFFFF_0000, 1'b0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    // R7 negative immediate, code ignored
    '{8'd7, 1'b1, 4'hB, 32'd7, 32'd9, 16'hFFFF, 1'b1, 1'b1, 32'hFFFF_FFF9, 1'b0, 32'h0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    // R7 + R4 immediate overflow with exception
    '{8'd7, 1'b1, 4'h7, 32'h7FFF_FFFF, 32'd0, 16'h0002, 1'b1, 1'b1, 32'hFFFF_FFFE, 1'b0, 32'h0, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    // R7 most negative times -1, exception disabled
    '{8'd7, 1'b1, 4'h6, 32'h8000_0000, 32'd0, 16'hFFFF, 1'b0, 1'b1, 32'h8000_0000, 1'b0, 32'h0, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    // R5 signed double
    '{8'd5, 1'b0, 4'h7, 32'hFFFF_FFFF, 32'd2, 16'h0, 1'b1, 1'b0, 32'h0, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    // R6 unsigned double, same operands
    '{8'd6, 1'b0, 4'hD, 32'hFFFF_FFFF, 32'd2, 16'h0, 1'b1, 1'b0, 32'h0, 1'b1, 32'h0000_0001, 32'hFFFF_FFFE, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    // R5 most negative squared
    '{8'd5, 1'b0, 4'h7, 32'h8000_0000, 32'h8000_0000, 16'h0, 1'b1, 1'b0, 32'h0, 1'b1, 32'h4000_0000, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    // R6 all-ones squared
    '{8'd6, 1'b0, 4'hD, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0, 1'b1, 1'b0, 32'h0, 1'b1, 32'hFFFF_FFFE, 32'h0000_0001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    // R9 unused code
    '{8'd9, 1'b0, 4'h4, 32'h8000_0000, 32'd2, 16'h0, 1'b1, 1'b0, 32'h0, 1'b0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input int req, input logic [127:0] got, input logic [127:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL R%0d: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic check_idle(input int req);
    chk(req, {123'd0, rd_we, acc_we, ov_we, cy_we, range_exc}, 128'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle(10); // R10 reset state
    rst_n = 1'b1;
    @(negedge clk);
    check_idle(8);  // R8 idle after reset

    for (int i = 0; i < NV; i++) begin
      imm_sel  = VECS[i].isel;
      op_code  = VECS[i].code;
      op_a     = VECS[i].a;
      op_b     = VECS[i].b;
      op_imm   = VECS[i].imm;
      range_en = VECS[i].en;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk(int'(VECS[i].req),
          {121'd0, rd_we, acc_we, ov_we, cy_we, range_exc,
           ov_we ? ov_val : 1'b0, cy_we ? cy_val : 1'b0},
          {121'd0, VECS[i].e_rdwe, VECS[i].e_accwe, VECS[i].e_ovwe, VECS[i].e_cywe,
           VECS[i].e_exc, VECS[i].e_ov, VECS[i].e_cy});
      if (VECS[i].e_rdwe) chk(int'(VECS[i].req), {96'd0, rd_data}, {96'd0, VECS[i].e_rd});
      if (VECS[i].e_accwe)
        chk(int'(VECS[i].req), {64'd0, acc_hi, acc_lo}, {64'd0, VECS[i].e_hi, VECS[i].e_lo});
      @(negedge clk);
      check_idle(8); // R8 strobes drop after an idle cycle
    end

    // R8 back-to-back requests: each result lands one cycle later
    imm_sel = 1'b0; op_code = 4'h6; op_a = 32'd6; op_b = 32'd7; range_en = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);
    chk(8, {96'd0, rd_data}, {96'd0, 32'd42});
    op_code = 4'hD; op_a = 32'h0000_0010; op_b = 32'h1000_0000;
    @(negedge clk);
    in_valid = 1'b0;
    chk(8, {64'd0, acc_we, rd_we, acc_hi, acc_lo}, {64'd0, 1'b1, 1'b0, 32'h1, 32'h0});

    // R10 reset mid-operation clears strobes
    in_valid = 1'b1; op_code = 4'h6;
    rst_n = 1'b0;
    @(negedge clk);
    check_idle(10);
    in_valid = 1'b0; rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule